// File: doc/BRIEF.md
# Channel Selection Shadow Register with Settling Guard

This block sits between the register interface of a converter and its analog input multiplexer. Software writes a channel code and a reference code into a holding register at any time and can read it back. The block copies the holding register into the active selection, which drives the multiplexer. The copy takes place on every clock while the selection is unlocked. A conversion-start strobe from the sequencer locks the active selection, which protects the sampling phase. A strobe in the last converter clock before completion copies the holding register once more and releases the lock, so a value written during a conversion applies to the next one.

Channel codes at or above a parameter `DIFF_BASE` select a differential pair behind a gain stage. That stage needs a fixed settling time after its input or its reference changes. The block counts this time in system clocks; the count is derived from a clock-frequency parameter and a settling time in nanoseconds. While the count runs, `settle_busy` is high. At each conversion start the block latches an invalid tag, and that tag stays with the result of the conversion.

Top module: `chsel_guard`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `hold_chan`, `hold_ref`, `act_chan`, `act_ref`, `settle_busy` and `conv_invalid` are all zero.
- R2: A cycle with `wr_en` high loads `wr_chan`/`wr_ref` into `hold_chan`/`hold_ref` at that clock edge, whether or not a conversion is running.
- R3: While unlocked, `act_chan`/`act_ref` take the value `hold_chan`/`hold_ref` had before each clock edge, so a write reaches the active outputs two edges after it is driven.
- R4: A `conv_start` edge loads the current holding value into the active outputs and locks them. While locked and `conv_last` is low, the active outputs stay unchanged, even when the holding register is written.
- R5: A `conv_last` edge during a lock loads the holding value into the active outputs and releases the lock.
- R6: When `conv_start` and `conv_last` are high in the same cycle, the start wins and the selection is locked after that edge.
- R7: A channel code is differential when it is at or above `DIFF_BASE` (4 in the bench configuration). An edge that makes a differential channel active with a channel code different from the one active before raises `settle_busy` for exactly `SETTLE_CYC` cycles, where `SETTLE_CYC` = ceil(`CLK_HZ` x `SETTLE_NS` / 1e9) (13 in the bench configuration).
- R8: An edge that loads a single-ended channel never starts or restarts the settling count. A count that is running continues down to zero.
- R9: A new triggering change while `settle_busy` is high restarts the count at its full length.
- R10: At a `conv_start` edge, `conv_invalid` becomes 1 when the loaded channel is differential and the settling count was running before that edge or starts at it. Otherwise it becomes 0. The tag holds until the next `conv_start`.
- R11: A change of the reference code alone, while a differential channel stays active, starts the settling count like a channel change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Software write strobe for the holding register |
| wr_chan | input | CHW | Channel code to write |
| wr_ref | input | REFW | Reference code to write |
| conv_start | input | 1 | Sequencer strobe: conversion begins |
| conv_last | input | 1 | Sequencer strobe: last converter clock before completion |
| hold_chan | output | CHW | Holding register channel readback |
| hold_ref | output | REFW | Holding register reference readback |
| act_chan | output | CHW | Active channel driving the multiplexer |
| act_ref | output | REFW | Active reference selection |
| settle_busy | output | 1 | Gain stage still settling |
| conv_invalid | output | 1 | Invalid tag for the conversion started last |

## Verification
The bench builds the block with a 3-bit channel code, a 2-bit reference code, `DIFF_BASE` = 4, and a 100 MHz / 125 ns setting that gives a 13-cycle settling count. This small configuration makes it possible to sweep all 32 channel/reference combinations through the holding and active paths. It also brings the settling window into reach cycle by cycle. With that window, conversion starts at the last busy edge and at the first idle edge can both be placed exactly, and retriggers can be placed anywhere inside the count.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

   // A channel code at or above the base selects a differential pair.
   function automatic logic code_is_diff(input int unsigned code, input int unsigned base);
      return code >= base;
   endfunction

   // Settling clocks: ceil(hz * ns / 1e9).
   function automatic longint unsigned settle_cycles(input longint unsigned hz,
                                                     input longint unsigned ns);
      return (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
   endfunction

endpackage

// File: rtl/chsel_hold.sv
module chsel_hold #(
   parameter int CHW  = 5,
   parameter int REFW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [CHW-1:0]  wr_chan,
   input  logic [REFW-1:0] wr_ref,
   output logic [CHW-1:0]  hold_chan,
   output logic [REFW-1:0] hold_ref
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_chan <= '0;
         hold_ref  <= '0;
      end else if (wr_en) begin
         hold_chan <= wr_chan;
         hold_ref  <= wr_ref;
      end
   end

endmodule

// File: rtl/chsel_track.sv
module chsel_track
   import chsel_pkg::*;
#(
   parameter int CHW       = 5,
   parameter int REFW      = 2,
   parameter int DIFF_BASE = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            conv_start,
   input  logic            conv_last,
   input  logic [CHW-1:0]  hold_chan,
   input  logic [REFW-1:0] hold_ref,
   output logic [CHW-1:0]  act_chan,
   output logic [REFW-1:0] act_ref,
   output logic            lock_q,
   output logic            hold_diff,
   output logic            trig
);

   logic open_w;
   logic differs;

   // The window is open outside a lock and in the closing cycle of one.
   assign open_w    = !lock_q || conv_last;
   assign differs   = (hold_chan != act_chan) || (hold_ref != act_ref);
   assign hold_diff = code_is_diff(32'(hold_chan), DIFF_BASE);
   assign trig      = open_w && differs && hold_diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
      end else if (conv_start) begin
         lock_q <= 1'b1;
      end else if (conv_last) begin
         lock_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_chan <= '0;
         act_ref  <= '0;
      end else if (open_w) begin
         act_chan <= hold_chan;
         act_ref  <= hold_ref;
      end
   end

endmodule

// File: rtl/chsel_settle.sv
module chsel_settle #(
   parameter int SETTLE_CYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic conv_start,
   input  logic hold_diff,
   output logic settle_busy,
   output logic conv_invalid
);

   generate
      if (SETTLE_CYC == 0) begin : g_no_timer
         assign settle_busy = 1'b0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) conv_invalid <= 1'b0;
            else if (conv_start) conv_invalid <= 1'b0;
         end
      end else begin : g_timer
         localparam int CNTW = $clog2(SETTLE_CYC + 1);
         logic [CNTW-1:0] cnt_q;

         assign settle_busy = (cnt_q != '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (trig) begin
               cnt_q <= CNTW'(SETTLE_CYC);
            end else if (settle_busy) begin
               cnt_q <= cnt_q - CNTW'(1);
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               conv_invalid <= 1'b0;
            end else if (conv_start) begin
               conv_invalid <= hold_diff && (settle_busy || trig);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/chsel_guard.sv
module chsel_guard
   import chsel_pkg::*;
#(
   parameter int          CHW       = 5,
   parameter int          REFW      = 2,
   parameter int          DIFF_BASE = 16,
   parameter longint      CLK_HZ    = 16_000_000,
   parameter longint      SETTLE_NS = 125_000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [CHW-1:0]  wr_chan,
   input  logic [REFW-1:0] wr_ref,
   input  logic            conv_start,
   input  logic            conv_last,
   output logic [CHW-1:0]  hold_chan,
   output logic [REFW-1:0] hold_ref,
   output logic [CHW-1:0]  act_chan,
   output logic [REFW-1:0] act_ref,
   output logic            settle_busy,
   output logic            conv_invalid
);

   localparam int SETTLE_CYC = int'(settle_cycles(CLK_HZ, SETTLE_NS));

   generate
      if (CHW < 1 || CHW > 16) begin : g_bad_chw
         $error("chsel_guard: CHW out of range");
      end
      if (REFW < 1 || REFW > 8) begin : g_bad_refw
         $error("chsel_guard: REFW out of range");
      end
      if (DIFF_BASE < 0 || DIFF_BASE > (1 << CHW)) begin : g_bad_base
         $error("chsel_guard: DIFF_BASE outside channel code space");
      end
      if (SETTLE_CYC >= (1 << 24)) begin : g_bad_settle
         $error("chsel_guard: settling count too large");
      end
   endgenerate

   logic lock_q;
   logic hold_diff;
   logic trig;

   chsel_hold #(.CHW(CHW), .REFW(REFW)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_chan   (wr_chan),
      .wr_ref    (wr_ref),
      .hold_chan (hold_chan),
      .hold_ref  (hold_ref)
   );

   chsel_track #(.CHW(CHW), .REFW(REFW), .DIFF_BASE(DIFF_BASE)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_start (conv_start),
      .conv_last  (conv_last),
      .hold_chan  (hold_chan),
      .hold_ref   (hold_ref),
      .act_chan   (act_chan),
      .act_ref    (act_ref),
      .lock_q     (lock_q),
      .hold_diff  (hold_diff),
      .trig       (trig)
   );

   chsel_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig         (trig),
      .conv_start   (conv_start),
      .hold_diff    (hold_diff),
      .settle_busy  (settle_busy),
      .conv_invalid (conv_invalid)
   );

endmodule

// File: rtl/chsel_guard_chk.sv
module chsel_guard_chk #(
   parameter int CHW       = 5,
   parameter int REFW      = 2,
   parameter int DIFF_BASE = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [CHW-1:0]  wr_chan,
   input logic [REFW-1:0] wr_ref,
   input logic            conv_start,
   input logic            conv_last,
   input logic [CHW-1:0]  hold_chan,
   input logic [REFW-1:0] hold_ref,
   input logic [CHW-1:0]  act_chan,
   input logic [REFW-1:0] act_ref,
   input logic            settle_busy,
   input logic            conv_invalid,
   input logic            lock_q
);

   p_hold_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (hold_chan == $past(wr_chan)) && (hold_ref == $past(wr_ref)));

   p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_q |=> (act_chan == $past(hold_chan)) && (act_ref == $past(hold_ref)));

   p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !conv_last) |=> $stable(act_chan) && $stable(act_ref));

   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && conv_last && !conv_start) |=> !lock_q && (act_chan == $past(hold_chan)));

   p_start_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && conv_last) |=> lock_q);

   p_rise_on_diff_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settle_busy) |-> (32'(act_chan) >= DIFF_BASE));

   p_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> conv_invalid ==
         ((32'(act_chan) >= DIFF_BASE) && (settle_busy || $past(settle_busy))));

   p_tag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_start |=> $stable(conv_invalid));

endmodule

bind chsel_guard chsel_guard_chk #(.CHW(CHW), .REFW(REFW), .DIFF_BASE(DIFF_BASE)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_chan      (wr_chan),
   .wr_ref       (wr_ref),
   .conv_start   (conv_start),
   .conv_last    (conv_last),
   .hold_chan    (hold_chan),
   .hold_ref     (hold_ref),
   .act_chan     (act_chan),
   .act_ref      (act_ref),
   .settle_busy  (settle_busy),
   .conv_invalid (conv_invalid),
   .lock_q       (lock_q)
);

// File: tb/chsel_guard_test.sv
module chsel_guard_test;

   localparam int CHW = 3;
   localparam int REFW = 2;
   localparam int BASE = 4;
   localparam int SCYC = 13; // ceil(100e6 * 125e-9)

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [CHW-1:0] wr_chan = '0;
   logic [REFW-1:0] wr_ref = '0;
   logic conv_start = 1'b0;
   logic conv_last = 1'b0;
   logic [CHW-1:0] hold_chan, act_chan;
   logic [REFW-1:0] hold_ref, act_ref;
   logic settle_busy, conv_invalid;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   chsel_guard #(.CHW(CHW), .REFW(REFW), .DIFF_BASE(BASE),
                 .CLK_HZ(100_000_000), .SETTLE_NS(125)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_ref(wr_ref),
      .conv_start(conv_start), .conv_last(conv_last),
      .hold_chan(hold_chan), .hold_ref(hold_ref), .act_chan(act_chan), .act_ref(act_ref),
      .settle_busy(settle_busy), .conv_invalid(conv_invalid));

   task automatic chk(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write(input int c, input int r);
      wr_en = 1'b1; wr_chan = CHW'(c); wr_ref = REFW'(r);
      step();
      wr_en = 1'b0;
   endtask

   task automatic pulse_start();
      conv_start = 1'b1; step(); conv_start = 1'b0;
   endtask

   task automatic pulse_last();
      conv_last = 1'b1; step(); conv_last = 1'b0;
   endtask

   // Counts busy cycles from the current (busy) cycle on.
   task automatic busy_len(output int n);
      n = settle_busy ? 1 : 0;
      for (int k = 0; k < 40; k++) begin
         step();
         if (settle_busy) n++;
      end
   endtask

   initial begin
      #(4 * 100_000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n;
      @(negedge clk); @(negedge clk);
      chk("R1 busy in reset", int'(settle_busy), 0);
      rst_n = 1'b1;
      step();
      chk("R1 hold", int'({hold_chan, hold_ref}), 0);
      chk("R1 act", int'({act_chan, act_ref}), 0);
      chk("R1 busy", int'(settle_busy), 0);
      chk("R1 tag", int'(conv_invalid), 0);

      // R2 / R3: full sweep of channel and reference codes.
      for (int c = 0; c < 8; c++) begin
         for (int r = 0; r < 4; r++) begin
            write(c, r);
            chk("R2 hold_chan", int'(hold_chan), c);
            chk("R2 hold_ref", int'(hold_ref), r);
            step();
            chk("R3 act_chan", int'(act_chan), c);
            chk("R3 act_ref", int'(act_ref), r);
         end
      end

      // R7: exact settling length after a single-ended to differential change.
      write(0, 0);
      repeat (20) step();
      write(5, 0);
      chk("R7 not busy before active", int'(settle_busy), 0);
      step();
      chk("R7 busy when active", int'(settle_busy), 1);
      busy_len(n);
      chk("R7 busy length", n, SCYC);

      // R8: single-ended changes leave the flag low.
      write(1, 0);
      write(2, 3);
      for (int k = 0; k < 4; k++) begin
         step();
         chk("R8 single-ended no settle", int'(settle_busy), 0);
      end
      chk("R8 act follows", int'(act_chan), 2);

      // R11: reference-only change on a differential channel.
      write(6, 0);
      repeat (20) step();
      chk("R11 settled", int'(settle_busy), 0);
      write(6, 2);
      step();
      chk("R11 ref change busy", int'(settle_busy), 1);
      repeat (20) step();

      // R9: retrigger restarts the full count.
      write(7, 2);
      step();
      repeat (5) step();
      write(4, 2);
      step();
      chk("R9 still busy at retrigger", int'(settle_busy), 1);
      busy_len(n);
      chk("R9 full length after retrigger", n, SCYC);

      // R4 / R5: lock and release with single-ended codes.
      write(1, 0);
      step();
      wr_en = 1'b1; wr_chan = 3'd2; wr_ref = 2'd1; conv_start = 1'b1;
      step();
      wr_en = 1'b0; conv_start = 1'b0;
      chk("R2 write at start", int'(hold_chan), 2);
      chk("R4 captured old hold", int'(act_chan), 1);
      step();
      chk("R4 frozen", int'(act_chan), 1);
      write(3, 3);
      chk("R4 frozen after write", int'({act_chan, act_ref}), 4);
      step();
      chk("R4 frozen later", int'(act_chan), 1);
      pulse_last();
      chk("R5 release loads hold", int'({act_chan, act_ref}), 15);
      write(0, 1);
      step();
      chk("R5 follows after release", int'({act_chan, act_ref}), 1);

      // R6: start and last together lock.
      conv_start = 1'b1; conv_last = 1'b1;
      step();
      conv_start = 1'b0; conv_last = 1'b0;
      write(2, 0);
      step();
      chk("R6 start wins", int'(act_chan), 0);
      pulse_last();
      chk("R6 released", int'(act_chan), 2);

      // R10: tag on a settled differential channel.
      write(4, 2);
      repeat (20) step();
      pulse_start();
      chk("R10 settled diff valid", int'(conv_invalid), 0);
      pulse_last();
      // Start on the last busy edge.
      write(5, 2);
      step();
      repeat (SCYC - 1) step();
      pulse_start();
      chk("R10 last busy edge invalid", int'(conv_invalid), 1);
      repeat (3) step();
      chk("R10 tag held", int'(conv_invalid), 1);
      pulse_last();
      repeat (20) step();
      // Start on the first idle edge.
      write(6, 2);
      step();
      repeat (SCYC) step();
      pulse_start();
      chk("R10 first idle edge valid", int'(conv_invalid), 0);
      pulse_last();
      // Single-ended conversion while busy.
      write(7, 2);
      step();
      write(2, 2);
      pulse_start();
      chk("R10 single-ended tag", int'(conv_invalid), 0);
      chk("R8 count continues", int'(settle_busy), 1);
      pulse_last();
      repeat (20) step();
      // Trigger on the start edge itself.
      write(5, 1);
      pulse_start();
      chk("R10 trigger at start", int'(conv_invalid), 1);
      chk("R7 busy from start edge", int'(settle_busy), 1);
      pulse_last();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule